// File: doc/BRIEF.md
# Power Management Configuration Timers

This block holds a 16-bit power management configuration word and runs the logic it controls. Two SMI timers count in millisecond ticks from a shared prescaler. The first is a one-shot software SMI timer with a long and a short timeout. The second is a free-running periodic SMI generator with four periods. The same word returns the live level of the power button on a read-only bit. A CPU sleep output is derived from the current sleep state, a processor speed-transition flag and an enable bit in the word.

Software writes the word with a single-cycle write strobe and reads it combinationally. A separate start strobe arms the one-shot timer. Each SMI request leaves the block as a one-cycle pulse for the SMI logic downstream. The number of clocks per millisecond and every timeout length are parameters, so a testbench can shrink the whole time base.

Top module: `pmcfg_timers`

## Requirements
- R1: After a synchronous reset the stored fields are zero, both SMI request outputs are low, and `reg_rdata` equals the power button level placed in bit 9 with every other bit zero.
- R2: A write stores bit 10 (software SMI speed), bit 5 (S1 sleep enable) and bits 1:0 (periodic rate). Bits 15:11, 8:6 and 4:2 always read zero, and writes to them or to bit 9 have no effect.
- R3: Bit 9 of `reg_rdata` shows the present level of `pwrbtn_lvl` in the same cycle, 0 for low and 1 for high.
- R4: The one-shot timeout is `SWSMI_LONG_MS` ticks when bit 10 is 0 and `SWSMI_SHORT_MS` ticks when it is 1. The bit is sampled in the cycle of the start strobe. `swsmi_req` rises in the clock after the tick that completes the count.
- R5: `swsmi_req` is high for exactly one cycle per timeout, and the timer then stays idle until the next start. A start while the timer is counting restarts the count from zero, and a start takes precedence over a tick in the same cycle.
- R6: Periodic rate code 00, 01, 10 and 11 selects `PER_MS_SEL0`, `PER_MS_SEL1`, `PER_MS_SEL2` and `PER_MS_SEL3` ticks (1 min, 32 s, 16 s and 8 s by default). Each time the period elapses, `persmi_req` is high for one cycle.
- R7: Any register write resets the periodic count to zero. No periodic request follows in the cycle after a write.
- R8: With `sleep_state` = 3'd1 (S1) and `speed_trans` low, `cpu_sleep` equals bit 5.
- R9: `cpu_sleep` is high whenever `sleep_state` is 3'd3, 3'd4 or 3'd5 (S3, S4, S5) or `speed_trans` is high, regardless of bit 5. It is low in S0 (3'd0) and for unused codes 2, 6 and 7 when `speed_trans` is low.
- R10: One millisecond tick occurs every `CLKS_PER_MS` clocks, counted from reset, so consecutive pulses at rate 11 are `PER_MS_SEL3*CLKS_PER_MS` clocks apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Single-cycle register write strobe |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Combinational read data |
| pwrbtn_lvl | input | 1 | Power button level |
| swsmi_start | input | 1 | Arms or restarts the one-shot SMI timer |
| sleep_state | input | 3 | Current sleep state code |
| speed_trans | input | 1 | Processor speed-state transition in progress |
| swsmi_req | output | 1 | One-shot SMI request pulse |
| persmi_req | output | 1 | Periodic SMI request pulse |
| cpu_sleep | output | 1 | CPU sleep output, active high |

## Verification
The one-shot timer is started with both speed settings, and it is restarted in the middle of a count. These runs distinguish a speed bit latched at the start from one read live, and a restart from a second overlapping timer. The periodic generator runs at all four rate codes, with writes placed in the middle of a period, so a wrong code mapping or a missing restart shows up as a shifted pulse. The sleep output is swept over all eight state codes against both enable values and both transition levels, which separates the S1 gate from the forced deep-state cases. A behavioural model checks every output on every clock.

// File: rtl/pmcfg_pkg.sv
package pmcfg_pkg;

    localparam int REG_W      = 16;
    localparam int BIT_SWFAST = 10;
    localparam int BIT_BTN    = 9;
    localparam int BIT_SLPEN  = 5;

    localparam logic [2:0] ST_S0 = 3'd0;
    localparam logic [2:0] ST_S1 = 3'd1;
    localparam logic [2:0] ST_S3 = 3'd3;
    localparam logic [2:0] ST_S4 = 3'd4;
    localparam logic [2:0] ST_S5 = 3'd5;

    typedef struct packed {
        logic       sw_fast;
        logic       slp_en;
        logic [1:0] per_sel;
    } cfg_t;

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic cfg_t cfg_from_word(input logic [REG_W-1:0] w);
        cfg_t c;
        c.sw_fast = w[BIT_SWFAST];
        c.slp_en  = w[BIT_SLPEN];
        c.per_sel = w[1:0];
        return c;
    endfunction

    function automatic logic [REG_W-1:0] word_from_cfg(input cfg_t c, input logic btn);
        logic [REG_W-1:0] w;
        w             = '0;
        w[BIT_SWFAST] = c.sw_fast;
        w[BIT_BTN]    = btn;
        w[BIT_SLPEN]  = c.slp_en;
        w[1:0]        = c.per_sel;
        return w;
    endfunction

    function automatic logic sleep_drive(input logic [2:0] st, input logic en,
                                         input logic trans);
        logic deep;
        deep = (st == ST_S3) || (st == ST_S4) || (st == ST_S5);
        return trans || deep || ((st == ST_S1) && en);
    endfunction

endpackage

// File: rtl/pmcfg_tick.sv
module pmcfg_tick #(
    parameter int CLKS_PER_MS = 33000
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int W = (CLKS_PER_MS > 1) ? $clog2(CLKS_PER_MS) : 1;
    localparam logic [W-1:0] LAST = W'(CLKS_PER_MS - 1);

    logic [W-1:0] phase;

    assign tick = (phase == LAST);

    always_ff @(posedge clk) begin
        if (rst)       phase <= '0;
        else if (tick) phase <= '0;
        else           phase <= phase + W'(1);
    end

    generate
        if (CLKS_PER_MS > 1) begin : g_spacing
            assert_tick_spacing_R10: assert property (@(posedge clk) disable iff (rst)
                tick |=> !tick);
        end
    endgenerate

endmodule

// File: rtl/pmcfg_oneshot.sv
module pmcfg_oneshot #(
    parameter int LONG_MS  = 64,
    parameter int SHORT_MS = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic start,
    input  logic fast,
    output logic req
);
    localparam int W = $clog2(pmcfg_pkg::max_of(LONG_MS, SHORT_MS) + 1);

    logic         running;
    logic [W-1:0] count;
    logic [W-1:0] limit;
    logic [W-1:0] count_nxt;

    assign count_nxt = count + W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            running <= 1'b0;
            count   <= '0;
            limit   <= '0;
            req     <= 1'b0;
        end else begin
            req <= 1'b0;
            if (start) begin
                running <= 1'b1;
                count   <= '0;
                limit   <= fast ? W'(SHORT_MS) : W'(LONG_MS);
            end else if (running && tick) begin
                count <= count_nxt;
                if (count_nxt == limit) begin
                    req     <= 1'b1;
                    running <= 1'b0;
                end
            end
        end
    end

    assert_single_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        req |=> !req);
    assert_start_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        start |=> !req);

endmodule

// File: rtl/pmcfg_periodic.sv
module pmcfg_periodic #(
    parameter int PER_MS_SEL0 = 60000,
    parameter int PER_MS_SEL1 = 32000,
    parameter int PER_MS_SEL2 = 16000,
    parameter int PER_MS_SEL3 = 8000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       restart,
    input  logic [1:0] sel,
    output logic       req
);
    localparam int MAXP = pmcfg_pkg::max_of(pmcfg_pkg::max_of(PER_MS_SEL0, PER_MS_SEL1),
                                            pmcfg_pkg::max_of(PER_MS_SEL2, PER_MS_SEL3));
    localparam int W = $clog2(MAXP + 1);

    logic [W-1:0] count;
    logic [W-1:0] last;

    always_comb begin
        unique case (sel)
            2'b00:   last = W'(PER_MS_SEL0 - 1);
            2'b01:   last = W'(PER_MS_SEL1 - 1);
            2'b10:   last = W'(PER_MS_SEL2 - 1);
            default: last = W'(PER_MS_SEL3 - 1);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
            req   <= 1'b0;
        end else begin
            req <= 1'b0;
            if (restart) begin
                count <= '0;
            end else if (tick) begin
                if (count == last) begin
                    req   <= 1'b1;
                    count <= '0;
                end else begin
                    count <= count + W'(1);
                end
            end
        end
    end

    assert_restart_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        restart |=> !req);

endmodule

// File: rtl/pmcfg_timers.sv
module pmcfg_timers
    import pmcfg_pkg::*;
#(
    parameter int CLKS_PER_MS    = 33000,
    parameter int SWSMI_LONG_MS  = 64,
    parameter int SWSMI_SHORT_MS = 2,
    parameter int PER_MS_SEL0    = 60000,
    parameter int PER_MS_SEL1    = 32000,
    parameter int PER_MS_SEL2    = 16000,
    parameter int PER_MS_SEL3    = 8000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr,
    input  logic [15:0] reg_wdata,
    output logic [15:0] reg_rdata,
    input  logic        pwrbtn_lvl,
    input  logic        swsmi_start,
    input  logic [2:0]  sleep_state,
    input  logic        speed_trans,
    output logic        swsmi_req,
    output logic        persmi_req,
    output logic        cpu_sleep
);
    cfg_t cfg;
    logic ms_tick;

    always_ff @(posedge clk) begin
        if (rst)         cfg <= '0;
        else if (reg_wr) cfg <= cfg_from_word(reg_wdata);
    end

    assign reg_rdata = word_from_cfg(cfg, pwrbtn_lvl);
    assign cpu_sleep = sleep_drive(sleep_state, cfg.slp_en, speed_trans);

    pmcfg_tick #(.CLKS_PER_MS(CLKS_PER_MS)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .tick (ms_tick)
    );

    pmcfg_oneshot #(.LONG_MS(SWSMI_LONG_MS), .SHORT_MS(SWSMI_SHORT_MS)) u_swsmi (
        .clk   (clk),
        .rst   (rst),
        .tick  (ms_tick),
        .start (swsmi_start),
        .fast  (cfg.sw_fast),
        .req   (swsmi_req)
    );

    pmcfg_periodic #(
        .PER_MS_SEL0(PER_MS_SEL0), .PER_MS_SEL1(PER_MS_SEL1),
        .PER_MS_SEL2(PER_MS_SEL2), .PER_MS_SEL3(PER_MS_SEL3)
    ) u_persmi (
        .clk     (clk),
        .rst     (rst),
        .tick    (ms_tick),
        .restart (reg_wr),
        .sel     (cfg.per_sel),
        .req     (persmi_req)
    );

    assert_cfg_store_R2: assert property (@(posedge clk) disable iff (rst)
        reg_wr |=> (reg_rdata[10] == $past(reg_wdata[10]) &&
                    reg_rdata[5]  == $past(reg_wdata[5])  &&
                    reg_rdata[1:0] == $past(reg_wdata[1:0])));
    assert_s1_gate_R8: assert property (@(posedge clk) disable iff (rst)
        (sleep_state == ST_S1 && !speed_trans && !reg_rdata[5]) |-> !cpu_sleep);
    assert_deep_sleep_R9: assert property (@(posedge clk) disable iff (rst)
        (sleep_state == ST_S3 || sleep_state == ST_S4 || sleep_state == ST_S5) |-> cpu_sleep);

endmodule

// File: tb/pmcfg_timers_bench.sv
module pmcfg_timers_bench;
    localparam int CPM = 4;
    localparam int SWL = 16;
    localparam int SWS = 3;
    localparam int P0 = 15, P1 = 8, P2 = 4, P3 = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        pwrbtn_lvl = 1'b0;
    logic        swsmi_start = 1'b0;
    logic [2:0]  sleep_state = 3'd0;
    logic        speed_trans = 1'b0;
    logic        swsmi_req, persmi_req, cpu_sleep;

    int checks = 0;
    int errors = 0;
    bit compare_on = 1'b0;

    always #5 clk = ~clk;

    pmcfg_timers #(
        .CLKS_PER_MS(CPM), .SWSMI_LONG_MS(SWL), .SWSMI_SHORT_MS(SWS),
        .PER_MS_SEL0(P0), .PER_MS_SEL1(P1), .PER_MS_SEL2(P2), .PER_MS_SEL3(P3)
    ) u_pmcfg_timers (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .pwrbtn_lvl(pwrbtn_lvl), .swsmi_start(swsmi_start),
        .sleep_state(sleep_state), .speed_trans(speed_trans),
        .swsmi_req(swsmi_req), .persmi_req(persmi_req), .cpu_sleep(cpu_sleep)
    );

    // behavioural reference state
    int m_phase, m_cnt, m_lim, m_pcnt;
    bit m_run, m_fast, m_slp, m_sw, m_per;
    bit [1:0] m_sel;

    function automatic int period_of(input bit [1:0] s);
        case (s)
            2'b00: return P0;
            2'b01: return P1;
            2'b10: return P2;
            default: return P3;
        endcase
    endfunction

    function automatic bit exp_sleep(input bit [2:0] st, input bit en, input bit tr);
        if (tr) return 1'b1;
        if (st >= 3 && st <= 5) return 1'b1;
        if (st == 1) return en;
        return 1'b0;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_phase = 0; m_cnt = 0; m_lim = 0; m_pcnt = 0;
            m_run = 0; m_fast = 0; m_slp = 0; m_sw = 0; m_per = 0; m_sel = 0;
        end else begin
            bit t;
            t = (m_phase == CPM - 1);
            m_phase = t ? 0 : m_phase + 1;
            m_sw = 0;
            if (swsmi_start) begin
                m_run = 1; m_cnt = 0; m_lim = m_fast ? SWS : SWL;
            end else if (m_run && t) begin
                m_cnt++;
                if (m_cnt == m_lim) begin m_sw = 1; m_run = 0; end
            end
            m_per = 0;
            if (reg_wr) m_pcnt = 0;
            else if (t) begin
                m_pcnt++;
                if (m_pcnt == period_of(m_sel)) begin m_per = 1; m_pcnt = 0; end
            end
            if (reg_wr) begin
                m_fast = reg_wdata[10]; m_slp = reg_wdata[5]; m_sel = reg_wdata[1:0];
            end
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (compare_on) begin
            logic [15:0] er;
            er = '0;
            er[10] = m_fast; er[9] = pwrbtn_lvl; er[5] = m_slp; er[1:0] = m_sel;
            check(reg_rdata == er, "R2 read data", reg_rdata, er);
            check(swsmi_req == m_sw, "R4 swsmi_req", swsmi_req, m_sw);
            check(persmi_req == m_per, "R6/R7 persmi_req", persmi_req, m_per);
            check(cpu_sleep == exp_sleep(sleep_state, m_slp, speed_trans),
                  "R9 cpu_sleep", cpu_sleep, exp_sleep(sleep_state, m_slp, speed_trans));
        end
    end

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #2;
    endtask

    task automatic write_reg(input logic [15:0] d);
        @(posedge clk); #2;
        reg_wr = 1'b1; reg_wdata = d;
        @(posedge clk); #2;
        reg_wr = 1'b0;
    endtask

    task automatic start_sw();
        @(posedge clk); #2;
        swsmi_start = 1'b1;
        @(posedge clk); #2;
        swsmi_start = 1'b0;
    endtask

    task automatic main_seq();
        int pulses;
        int first_t, gap;
        cycles(4);
        rst = 1'b0;
        @(negedge clk);
        check(reg_rdata == 16'h0000, "R1 reset read", reg_rdata, 0);
        check(swsmi_req == 0 && persmi_req == 0, "R1 reset requests",
              {swsmi_req, persmi_req}, 0);
        compare_on = 1'b1;
        #2;
        // live button bit
        pwrbtn_lvl = 1'b1; #1;
        check(reg_rdata[9] == 1'b1, "R3 button high", reg_rdata[9], 1);
        pwrbtn_lvl = 1'b0; #1;
        check(reg_rdata[9] == 1'b0, "R3 button low", reg_rdata[9], 0);
        // reserved and read-only bits ignored
        write_reg(16'hFFFF);
        @(negedge clk);
        check(reg_rdata == 16'h0423, "R2 write all ones", reg_rdata, 16'h0423);
        write_reg(16'h0000);
        // long one-shot
        start_sw();
        pulses = 0;
        for (int i = 0; i < (SWL + 4) * CPM; i++) begin
            @(negedge clk); if (swsmi_req) pulses++;
        end
        check(pulses == 1, "R5 one pulse per start", pulses, 1);
        // short one-shot, speed bit changed after start is not used
        write_reg(16'h0400);
        start_sw();
        write_reg(16'h0000);
        cycles((SWS + 2) * CPM);
        // restart mid-count
        start_sw();
        cycles(8 * CPM);
        start_sw();
        pulses = 0;
        for (int i = 0; i < (SWL + 2) * CPM; i++) begin
            @(negedge clk); if (swsmi_req) pulses++;
        end
        check(pulses == 1, "R5 restart gives single pulse", pulses, 1);
        // start and write colliding
        fork
            start_sw();
            write_reg(16'h0401);
        join
        cycles((SWL + 2) * CPM);
        // every periodic rate, writes mid-period
        for (int s = 0; s < 4; s++) begin
            write_reg(16'(s));
            cycles(period_of(2'(s)) * CPM * 2 + 3);
            write_reg(16'(s));
            cycles(period_of(2'(s)) * CPM * 3);
        end
        // R10 pulse spacing at rate 11
        write_reg(16'h0003);
        @(negedge clk);
        while (!persmi_req) @(negedge clk);
        first_t = 0;
        @(negedge clk);
        while (!persmi_req) begin @(negedge clk); first_t++; end
        gap = first_t + 1;
        check(gap == P3 * CPM, "R10 periodic spacing", gap, P3 * CPM);
        // R7 write mid-period delays next pulse
        write_reg(16'h0003);
        pulses = 0;
        for (int i = 0; i < P3 * CPM - CPM; i++) begin
            @(negedge clk); if (persmi_req) pulses++;
        end
        check(pulses == 0, "R7 no pulse right after write", pulses, 0);
        // sleep output sweep
        for (int en = 0; en < 2; en++) begin
            write_reg(en ? 16'h0020 : 16'h0000);
            for (int tr = 0; tr < 2; tr++) begin
                for (int st = 0; st < 8; st++) begin
                    #1; sleep_state = 3'(st); speed_trans = 1'(tr);
                    @(negedge clk);
                    if (st == 1 && tr == 0)
                        check(cpu_sleep == 1'(en), "R8 S1 gate", cpu_sleep, en);
                    else
                        check(cpu_sleep == exp_sleep(3'(st), 1'(en), 1'(tr)),
                              "R9 forced/quiet", cpu_sleep, exp_sleep(3'(st), 1'(en), 1'(tr)));
                end
            end
        end
        sleep_state = 3'd0; speed_trans = 1'b0;
        cycles(4);
    endtask

    initial begin
        fork
            main_seq();
            begin
                cycles(150000);
                errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        compare_on = 1'b0;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule